// File: doc/BRIEF.md
# Commutation Preload Control Unit

This block stages the output configuration of several PWM channels ahead of time and switches all of it over in a single clock edge. Each channel has a 3-bit output mode and two enable bits, one for the main output and one for the complementary output. Software writes the next step's values into shadow (preload) registers through a simple write port. The active configuration that drives the downstream output stage changes only when a commutation event occurs. This is how the stepped commutation sequence of a brushless motor is advanced without glitches between channels.

A commutation event comes from either of two sources. The first is a one-cycle software generate strobe. The second is a rising edge on an asynchronous hardware trigger input, which is first passed through a two-flop synchroniser. Every event sets a sticky commutation flag. An interrupt request is raised while that flag is set and the interrupt enable bit is 1. The PWM generation itself lies outside this block.

Top module: `com_preload_ctrl`

## Requirements
- R1: After reset every channel's active mode is 0 (frozen), both active enables are 0, and `com_flag` and `com_irq` are 0.
- R2: A preload write never changes `act_mode`, `act_en_main` or `act_en_comp` unless a commutation event happens in the same cycle, in which case only the event's transfer is seen.
- R3: When `sw_gen` is 1 at a rising clock edge, every channel's active mode and enables take that channel's preload values at that same edge, all channels together.
- R4: When `trig_in` is sampled 1 at edge k after being sampled 0 at edge k-1, the active configuration is loaded at edge k+2.
- R5: Holding `trig_in` high, or taking it from high to low, causes no further event.
- R6: Every commutation event sets `com_flag` at the same edge that loads the active configuration.
- R7: `com_flag` stays set until `flag_clr` is 1 at an edge. A commutation event at the same edge as a clear wins, and the flag stays set.
- R8: `com_irq` is 1 exactly when `com_flag` is 1 and `irq_en` is 1.
- R9: A preload write at the same edge as a commutation event goes into the preload register only. That event transfers the preload value held before the write, and the newly written value reaches the active outputs at the next event.
- R10: A write with `wr_ch` equal to or above the channel count changes no channel's preload.
- R11: When a channel is written several times between events, the last write is the one transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Preload write strobe |
| wr_ch | input | CH_W | Channel index of the write |
| wr_mode | input | 3 | Output mode to preload |
| wr_en_main | input | 1 | Main output enable to preload |
| wr_en_comp | input | 1 | Complementary output enable to preload |
| sw_gen | input | 1 | Software commutation strobe, one cycle |
| trig_in | input | 1 | Asynchronous hardware trigger; its rising edge is an event |
| irq_en | input | 1 | Commutation interrupt enable |
| flag_clr | input | 1 | Flag clear (write of 0 to the flag) |
| act_mode | output | NUM_CH*3 | Active modes, channel c at bits [3c+2:3c] |
| act_en_main | output | NUM_CH | Active main output enables, bit c = channel c |
| act_en_comp | output | NUM_CH | Active complementary output enables, bit c = channel c |
| com_flag | output | 1 | Sticky commutation flag |
| com_irq | output | 1 | Commutation interrupt request |

## Verification
The bench targets write and event collisions. A design that forwards the new write through the load would show the new value one event early. It also checks a clear at the same edge as an event; a design that gave the clear priority would lose the flag. Long high trigger levels and falling trigger edges are driven, where a level-sensitive design would reload at every edge. Out-of-range channel indices are written, which an incomplete decode would alias onto a real channel. The timing of the trigger path is checked edge by edge, so a synchroniser one stage short or long is caught.

// File: rtl/com_pkg.sv
`timescale 1ns/1ps
package com_pkg;
  localparam int unsigned CP_MODE_W = 3;

  typedef enum logic [CP_MODE_W-1:0] {
    MODE_FROZEN   = 3'd0,
    MODE_SET_HI   = 3'd1,
    MODE_SET_LO   = 3'd2,
    MODE_TOGGLE   = 3'd3,
    MODE_FORCE_LO = 3'd4,
    MODE_FORCE_HI = 3'd5,
    MODE_PWM_A    = 3'd6,
    MODE_PWM_B    = 3'd7
  } out_mode_e;

  typedef struct packed {
    logic [CP_MODE_W-1:0] mode;
    logic                 en_main;
    logic                 en_comp;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{mode: MODE_FROZEN, en_main: 1'b0, en_comp: 1'b0};

  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic flag_next(input logic cur, input logic evt, input logic clr);
    if (evt) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic chan_cfg_t make_cfg(input logic [CP_MODE_W-1:0] m,
                                         input logic em, input logic ec);
    chan_cfg_t r;
    r.mode    = m;
    r.en_main = em;
    r.en_comp = ec;
    return r;
  endfunction
endpackage

// File: rtl/com_trig_sync.sv
`timescale 1ns/1ps
module com_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  import com_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = edge_up(chain_q[STAGES-1], prev_q);
endmodule

// File: rtl/com_chan_regs.sv
`timescale 1ns/1ps
module com_chan_regs
  import com_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  chan_cfg_t wr_cfg,
  input  logic      load,
  output chan_cfg_t act_cfg
);
  chan_cfg_t pre_q;
  chan_cfg_t act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= CFG_RESET;
    else if (wr_hit) pre_q <= wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= CFG_RESET;
    else if (load) act_q <= pre_q;
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/com_flag_ctrl.sv
`timescale 1ns/1ps
module com_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  import com_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, evt, clr);
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/com_preload_ctrl.sv
`timescale 1ns/1ps
module com_preload_ctrl
  import com_pkg::*;
#(
  parameter  int NUM_CH      = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int MW          = CP_MODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_ch,
  input  logic [MW-1:0]        wr_mode,
  input  logic                 wr_en_main,
  input  logic                 wr_en_comp,
  input  logic                 sw_gen,
  input  logic                 trig_in,
  input  logic                 irq_en,
  input  logic                 flag_clr,
  output logic [NUM_CH*MW-1:0] act_mode,
  output logic [NUM_CH-1:0]    act_en_main,
  output logic [NUM_CH-1:0]    act_en_comp,
  output logic                 com_flag,
  output logic                 com_irq
);
  logic      trig_rise;
  logic      com_evt;
  chan_cfg_t wr_cfg;

  com_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_rise)
  );

  assign com_evt = sw_gen | trig_rise;
  assign wr_cfg  = make_cfg(wr_mode, wr_en_main, wr_en_comp);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic      hit;
    chan_cfg_t act;
    assign hit = wr_en && (wr_ch == CH_W'(c));
    com_chan_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit),
      .wr_cfg  (wr_cfg),
      .load    (com_evt),
      .act_cfg (act)
    );
    assign act_mode[c*MW +: MW] = act.mode;
    assign act_en_main[c]       = act.en_main;
    assign act_en_comp[c]       = act.en_comp;
  end

  com_flag_ctrl u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (com_evt),
    .clr    (flag_clr),
    .irq_en (irq_en),
    .flag   (com_flag),
    .irq    (com_irq)
  );
endmodule

// File: rtl/com_preload_chk.sv
`timescale 1ns/1ps
module com_preload_chk
  import com_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sw_gen,
  input logic                        trig_in,
  input logic                        irq_en,
  input logic                        flag_clr,
  input logic                        com_evt,
  input logic                        trig_rise,
  input logic [NUM_CH*CP_MODE_W-1:0] act_mode,
  input logic [NUM_CH-1:0]           act_en_main,
  input logic [NUM_CH-1:0]           act_en_comp,
  input logic                        com_flag,
  input logic                        com_irq
);
  AST_ACT_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !com_evt |=> ($stable(act_mode) && $stable(act_en_main) && $stable(act_en_comp))); // R2

  AST_SW_GEN_IS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gen |-> com_evt); // R3

  AST_TRIG_RISE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |-> ($past(trig_in, 2) && !$past(trig_in, 3))); // R4

  AST_NO_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_gen && !$past(trig_in, 2)) |-> !com_evt); // R5

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> com_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (com_flag && !flag_clr) |=> com_flag); // R7

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!com_evt && flag_clr) |=> !com_flag); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    com_irq |-> (com_flag && irq_en)); // R8
endmodule

bind com_preload_ctrl com_preload_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_com_preload_ctrl.sv
`timescale 1ns/1ps
module test_com_preload_ctrl;
  localparam int NCH = 3;
  localparam int CW  = 2;
  localparam int MW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_en_main = 0, wr_en_comp = 0;
  logic [CW-1:0] wr_ch = '0;
  logic [MW-1:0] wr_mode = '0;
  logic sw_gen = 0, trig_in = 0, irq_en = 0, flag_clr = 0;
  logic [NCH*MW-1:0] act_mode;
  logic [NCH-1:0] act_en_main, act_en_comp;
  logic com_flag, com_irq;

  com_preload_ctrl #(.NUM_CH(NCH)) i_com_preload_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_mode(wr_mode),
    .wr_en_main(wr_en_main), .wr_en_comp(wr_en_comp), .sw_gen(sw_gen),
    .trig_in(trig_in), .irq_en(irq_en), .flag_clr(flag_clr),
    .act_mode(act_mode), .act_en_main(act_en_main), .act_en_comp(act_en_comp),
    .com_flag(com_flag), .com_irq(com_irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench model: 5-bit word per channel = {mode, main, comp}
  logic [4:0] m_pre [NCH];
  logic [4:0] m_act [NCH];
  logic m_flag;
  logic [2:0] m_hist; // trig_in samples at the last three edges, [0] newest

  function automatic logic [4:0] pack5(input logic [2:0] m, input logic a, input logic b);
    return {m, a, b};
  endfunction

  function automatic logic trig_event(input logic [2:0] h);
    // event when samples from two and three edges ago show 0 then 1
    return h[1] && !h[2];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin m_pre[c] = '0; m_act[c] = '0; end
    m_flag = 0;
    m_hist = '0;
  endtask

  task automatic model_edge();
    logic evt;
    evt = sw_gen || trig_event(m_hist);
    if (evt) for (int c = 0; c < NCH; c++) m_act[c] = m_pre[c];
    if (wr_en && int'(wr_ch) < NCH) m_pre[wr_ch] = pack5(wr_mode, wr_en_main, wr_en_comp);
    if (evt) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    m_hist = {m_hist[1:0], trig_in};
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [4:0] got;
      got = pack5(act_mode[c*MW +: MW], act_en_main[c], act_en_comp[c]);
      checks++;
      if (got !== m_act[c]) begin
        errors++;
        $display("FAIL %s ch%0d active cfg: got %h expected %h", tag, c, got, m_act[c]);
      end
    end
    checks++;
    if (com_flag !== m_flag) begin
      errors++;
      $display("FAIL %s R6 flag: got %b expected %b", tag, com_flag, m_flag);
    end
    checks++;
    if (com_irq !== (m_flag && irq_en)) begin
      errors++;
      $display("FAIL %s R8 irq: got %b expected %b", tag, com_irq, m_flag && irq_en);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    sw_gen = 0; wr_en = 0; flag_clr = 0;
    check_all(tag);
  endtask

  task automatic put(input int ch, input logic [2:0] m, input logic a, input logic b);
    wr_en = 1; wr_ch = CW'(ch); wr_mode = m; wr_en_main = a; wr_en_comp = b;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    cycle("R1 after release");

    // R2: writes alone never reach the active outputs
    put(0, 3'd6, 1, 1); cycle("R2");
    put(1, 3'd7, 1, 0); cycle("R2");
    put(2, 3'd3, 0, 1); cycle("R2");
    repeat (3) cycle("R2 hold");

    // R3 software strobe, R6 flag, R8 irq
    sw_gen = 1; cycle("R3 sw load");
    irq_en = 1; cycle("R8 irq on");
    irq_en = 0; cycle("R8 irq off");
    irq_en = 1;
    // R7 clear, then clear together with event
    flag_clr = 1; cycle("R7 clear");
    cycle("R7 stays clear");
    flag_clr = 1; sw_gen = 1; cycle("R7 event beats clear");
    flag_clr = 1; cycle("R7 clear again");

    // R9 write at the event edge
    put(0, 3'd2, 0, 1); sw_gen = 1; cycle("R9 collide");
    cycle("R9 not yet");
    sw_gen = 1; cycle("R9 next event");

    // R10 out-of-range channel, R11 last write wins
    put(3, 3'd5, 1, 1); cycle("R10 bad index");
    put(1, 3'd1, 0, 0); cycle("R11 first");
    put(1, 3'd4, 1, 0); cycle("R11 second");
    sw_gen = 1; cycle("R10 R11 load");

    // R4 trigger rise timing, R5 held level and falling edge
    put(2, 3'd5, 1, 1); cycle("R4 prep");
    flag_clr = 1; cycle("R4 prep");
    trig_in = 1; cycle("R4 edge k");
    cycle("R4 edge k+1");
    cycle("R4 edge k+2");
    put(2, 3'd0, 0, 0); cycle("R5 held high");
    repeat (6) cycle("R5 held high");
    trig_in = 0;
    repeat (5) cycle("R5 falling");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(1, 0) == 1)
        put($urandom_range(3, 0), 3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
            1'($urandom_range(1, 0)));
      sw_gen   = ($urandom_range(15, 0) == 0);
      flag_clr = ($urandom_range(5, 0) == 0);
      if ($urandom_range(7, 0) == 0) trig_in = ~trig_in;
      if ($urandom_range(15, 0) == 0) irq_en = ~irq_en;
      cycle("R3 R4 R7 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule